// File: doc/BRIEF.md
# Three-Mode Interrupt Response Unit

This unit decides, for an 8-bit processor core, when an interrupt is taken and where execution resumes. It watches a level-sensitive maskable request and an edge-sensitive non-maskable request. It holds the two interrupt-enable flip-flops, which are written by strobes from the instruction decoder. When it accepts an interrupt, it asks the core to save the program counter on the stack. It then gives the core a resume address, and in one mode it also gives an instruction byte that the core executes in place of a fetched opcode.

Three maskable response modes can be selected. The fixed mode always resumes at one address. The injected-instruction mode passes on the byte driven by the interrupting device and reports the restart address that this byte encodes. The table mode reads a 16-bit pointer from memory, at an address built from the page register and the device byte. The non-maskable path always wins. It saves the current enable state in the second flip-flop, so that a return-from-NMI strobe can put it back.

Top module: `irq_response_unit`

## Requirements
- R1: After reset, both enable flip-flops are 0, the mode is 0 (injected instruction), and take_o, push_req_o, inject_o and rd_req_o are all 0.
- R2: The enable strobe sets both flip-flops. The disable strobe clears both. If both strobes arrive in the same cycle, the flip-flops are cleared.
- R3: The mode-load strobe stores code 0 (injected instruction), code 1 (fixed) or code 2 (table). Code 3 leaves the stored mode unchanged.
- R4: A maskable request is accepted only while the first flip-flop is 1 and the unit is idle. Acceptance clears both flip-flops and raises push_req_o in the cycle after the request is sampled.
- R5: In mode 1, take_o rises in the cycle after acceptance with target 0x0038 and inject_o at 0.
- R6: In mode 0, take_o rises in the cycle after acceptance with inject_o at 1 and inject_op_o equal to the device byte. The target is 0x00 followed by {00, byte bits 5:3, 000}.
- R7: In mode 2, rd_req_o is high for the two cycles after acceptance. The first read is at {page, byte with bit 0 forced to 0} and the second read is at that address plus one. Read data must be valid in the cycle after each request. take_o rises one cycle after the second data arrives, with target {second byte, first byte}.
- R8: A rising edge on nmi_i is accepted whatever the state of the flip-flops. It gives target 0x0066 with push_req_o. The first flip-flop's value is copied into the second, and the first is cleared. A level held high does not trigger again.
- R9: A non-maskable edge takes priority over a maskable request sampled in the same cycle. The maskable request stays blocked until the first flip-flop is set again.
- R10: A non-maskable edge that arrives during a table read is held. It is served after the table-mode take, and one idle cycle separates the two takes.
- R11: The return-from-NMI strobe copies the second flip-flop into the first.
- R12: take_o and push_req_o are single-cycle pulses. Two acceptances are always separated by at least one cycle with take_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Maskable interrupt request, level |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| en_stb_i | input | 1 | Decoder strobe: enable interrupts |
| dis_stb_i | input | 1 | Decoder strobe: disable interrupts |
| nmi_ret_stb_i | input | 1 | Decoder strobe: return from non-maskable handler |
| mode_ld_i | input | 1 | Decoder strobe: load response mode |
| mode_val_i | input | 2 | Mode code to load |
| page_i | input | 8 | Page register, high byte of the table address |
| dev_byte_i | input | 8 | Byte supplied by the interrupting device |
| rd_data_i | input | 8 | Memory read data, valid one cycle after rd_req_o |
| take_o | output | 1 | Pulse: resume at target_o |
| target_o | output | 16 | Resume address |
| inject_o | output | 1 | With take_o: execute inject_op_o as the next instruction |
| inject_op_o | output | 8 | Injected instruction byte |
| push_req_o | output | 1 | Pulse: core must stack the program counter |
| rd_req_o | output | 1 | Memory read request for a table entry |
| rd_addr_o | output | 16 | Memory read address |
| iff1_o | output | 1 | First interrupt-enable flip-flop |
| iff2_o | output | 1 | Second interrupt-enable flip-flop |
| mode_o | output | 2 | Stored response mode |

## Verification
The assertions check, on every cycle, the properties that hold regardless of scenario. These are: the take and push pulses are one cycle wide, the enable flip-flop is clear whenever a push is signalled, an injection always comes with a take, and the table reads form an even/odd pair. They also check that the stored mode is never 3 and that the enable, disable and return strobes have their effect in the following cycle. Some results depend on a particular input pattern, and only the bench scenarios can show them. These are the resume addresses in each mode, the latency from request to take, the NMI overriding a maskable request in the same cycle, a held NMI level not triggering again, and an NMI arriving during a table read being held until the read finishes.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    IM_INJECT = 2'd0,
    IM_FIXED  = 2'd1,
    IM_TABLE  = 2'd2
  } im_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RD_LO = 2'd1,
    SQ_RD_HI = 2'd2,
    SQ_FIN   = 2'd3
  } seq_state_e;

  localparam logic [1:0] MODE_RESERVED = 2'd3;

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic svc_i,
  output logic nmi_req_o
);

  logic nmi_d_q;
  logic pend_q;
  logic pend_n;
  logic rise;

  always_comb begin
    rise      = nmi_i & ~nmi_d_q;
    nmi_req_o = rise | pend_q;
    pend_n    = nmi_req_o & ~svc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_d_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      nmi_d_q <= nmi_i;
      pend_q  <= pend_n;
    end
  end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nmi_take_i,
  input  logic       irq_take_i,
  input  logic       en_i,
  input  logic       dis_i,
  input  logic       ret_i,
  input  logic       mode_ld_i,
  input  logic [1:0] mode_val_i,
  output logic       iff1_o,
  output logic       iff2_o,
  output logic [1:0] mode_o
);

  logic       iff1_q, iff2_q, iff1_n, iff2_n;
  logic [1:0] mode_q, mode_n;
  logic       iff_en;
  logic       mode_en;

  always_comb begin
    iff1_n = iff1_q;
    iff2_n = iff2_q;
    if (nmi_take_i) begin
      iff1_n = 1'b0;
      iff2_n = iff1_q;
    end else if (irq_take_i || dis_i) begin
      iff1_n = 1'b0;
      iff2_n = 1'b0;
    end else if (en_i) begin
      iff1_n = 1'b1;
      iff2_n = 1'b1;
    end else if (ret_i) begin
      iff1_n = iff2_q;
    end
    iff_en  = nmi_take_i | irq_take_i | dis_i | en_i | ret_i;
    mode_en = mode_ld_i & (mode_val_i != MODE_RESERVED);
    mode_n  = mode_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      mode_q <= IM_INJECT;
    end else begin
      if (iff_en) begin
        iff1_q <= iff1_n;
        iff2_q <= iff2_n;
      end
      if (mode_en) begin
        mode_q <= mode_n;
      end
    end
  end

  assign iff1_o = iff1_q;
  assign iff2_o = iff2_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int unsigned NMI_VEC = 'h66,
  parameter int unsigned FIX_VEC = 'h38,
  localparam int         AW      = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nmi_take_i,
  input  logic          irq_take_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] page_i,
  input  logic [DW-1:0] dev_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          idle_o,
  output logic          take_o,
  output logic [AW-1:0] target_o,
  output logic          inject_o,
  output logic [DW-1:0] inject_op_o,
  output logic          push_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o
);

  seq_state_e    state_q, state_n;
  logic [AW-1:0] tbl_q, tbl_n;
  logic [DW-1:0] lo_q, lo_n;
  logic [AW-1:0] target_q, target_n;
  logic [DW-1:0] op_q, op_n;
  logic          take_q, take_n;
  logic          inject_q, inject_n;
  logic          push_q, push_n;
  logic [AW-1:0] rst_addr;

  assign rst_addr = {{(AW-6){1'b0}}, dev_i[5:3], 3'b000};

  always_comb begin
    state_n  = state_q;
    tbl_n    = tbl_q;
    lo_n     = lo_q;
    target_n = target_q;
    op_n     = op_q;
    take_n   = 1'b0;
    inject_n = 1'b0;
    push_n   = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (nmi_take_i) begin
          take_n   = 1'b1;
          push_n   = 1'b1;
          target_n = AW'(NMI_VEC);
        end else if (irq_take_i) begin
          push_n = 1'b1;
          if (mode_i == IM_TABLE) begin
            tbl_n   = {page_i, dev_i[DW-1:1], 1'b0};
            state_n = SQ_RD_LO;
          end else if (mode_i == IM_INJECT) begin
            take_n   = 1'b1;
            inject_n = 1'b1;
            op_n     = dev_i;
            target_n = rst_addr;
          end else begin
            take_n   = 1'b1;
            target_n = AW'(FIX_VEC);
          end
        end
      end
      SQ_RD_LO: state_n = SQ_RD_HI;
      SQ_RD_HI: begin
        lo_n    = rd_data_i;
        state_n = SQ_FIN;
      end
      SQ_FIN: begin
        take_n   = 1'b1;
        target_n = {rd_data_i, lo_q};
        state_n  = SQ_IDLE;
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SQ_IDLE;
      tbl_q    <= '0;
      lo_q     <= '0;
      target_q <= '0;
      op_q     <= '0;
      take_q   <= 1'b0;
      inject_q <= 1'b0;
      push_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      tbl_q    <= tbl_n;
      lo_q     <= lo_n;
      target_q <= target_n;
      op_q     <= op_n;
      take_q   <= take_n;
      inject_q <= inject_n;
      push_q   <= push_n;
    end
  end

  assign idle_o      = (state_q == SQ_IDLE) && !take_q;
  assign rd_req_o    = (state_q == SQ_RD_LO) || (state_q == SQ_RD_HI);
  assign rd_addr_o   = (state_q == SQ_RD_HI) ? (tbl_q | AW'(1)) : tbl_q;
  assign take_o      = take_q;
  assign target_o    = target_q;
  assign inject_o    = inject_q;
  assign inject_op_o = op_q;
  assign push_o      = push_q;

endmodule

// File: rtl/irq_response_unit.sv
module irq_response_unit #(
  parameter int          DW      = 8,
  parameter int unsigned NMI_VEC = 'h66,
  parameter int unsigned FIX_VEC = 'h38,
  localparam int         AW      = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_req_i,
  input  logic          nmi_i,
  input  logic          en_stb_i,
  input  logic          dis_stb_i,
  input  logic          nmi_ret_stb_i,
  input  logic          mode_ld_i,
  input  logic [1:0]    mode_val_i,
  input  logic [DW-1:0] page_i,
  input  logic [DW-1:0] dev_byte_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          take_o,
  output logic [AW-1:0] target_o,
  output logic          inject_o,
  output logic [DW-1:0] inject_op_o,
  output logic          push_req_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          iff1_o,
  output logic          iff2_o,
  output logic [1:0]    mode_o
);

  logic rst_meta_q;
  logic rst_sync_q;
  logic nmi_req;
  logic idle;
  logic nmi_take;
  logic irq_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign nmi_take = nmi_req & idle;
  assign irq_take = irq_req_i & iff1_o & idle & ~nmi_req;

  irq_nmi_edge u_nmi (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .nmi_i     (nmi_i),
    .svc_i     (nmi_take),
    .nmi_req_o (nmi_req)
  );

  irq_flag_ctrl u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .nmi_take_i (nmi_take),
    .irq_take_i (irq_take),
    .en_i       (en_stb_i),
    .dis_i      (dis_stb_i),
    .ret_i      (nmi_ret_stb_i),
    .mode_ld_i  (mode_ld_i),
    .mode_val_i (mode_val_i),
    .iff1_o     (iff1_o),
    .iff2_o     (iff2_o),
    .mode_o     (mode_o)
  );

  irq_vector_seq #(
    .DW      (DW),
    .NMI_VEC (NMI_VEC),
    .FIX_VEC (FIX_VEC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .nmi_take_i  (nmi_take),
    .irq_take_i  (irq_take),
    .mode_i      (mode_o),
    .page_i      (page_i),
    .dev_i       (dev_byte_i),
    .rd_data_i   (rd_data_i),
    .idle_o      (idle),
    .take_o      (take_o),
    .target_o    (target_o),
    .inject_o    (inject_o),
    .inject_op_o (inject_op_o),
    .push_o      (push_req_o),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o)
  );

endmodule

// File: rtl/irq_response_unit_chk.sv
module irq_response_unit_chk #(
  parameter int  DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          en_stb_i,
  input logic          dis_stb_i,
  input logic          nmi_ret_stb_i,
  input logic          take_o,
  input logic          inject_o,
  input logic          push_req_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          iff1_o,
  input logic          iff2_o,
  input logic [1:0]    mode_o
);

  AST_TAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    take_o |=> !take_o); // R12

  AST_PUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    push_req_o |=> !push_req_o); // R12

  AST_ACCEPT_MASKS: assert property (@(posedge clk_i) disable iff (!rst_n)
    push_req_o |-> !iff1_o); // R4

  AST_INJECT_WITH_TAKE: assert property (@(posedge clk_i) disable iff (!rst_n)
    inject_o |-> take_o); // R6

  AST_TABLE_EVEN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_req_o && !$past(rd_req_o)) |-> !rd_addr_o[0]); // R7

  AST_TABLE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_req_o && !rd_addr_o[0]) |=> (rd_req_o && rd_addr_o[0])); // R7

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_o != 2'd3); // R3

  AST_ENABLE_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_stb_i && !dis_stb_i) |=> (iff1_o || push_req_o)); // R2

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    dis_stb_i |=> !iff1_o); // R2

  AST_RETURN_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (nmi_ret_stb_i && !en_stb_i && !dis_stb_i) |=>
      ((iff1_o == $past(iff2_o)) || push_req_o)); // R11

endmodule

bind irq_response_unit irq_response_unit_chk #(.DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_sync_q),
  .en_stb_i      (en_stb_i),
  .dis_stb_i     (dis_stb_i),
  .nmi_ret_stb_i (nmi_ret_stb_i),
  .take_o        (take_o),
  .inject_o      (inject_o),
  .push_req_o    (push_req_o),
  .rd_req_o      (rd_req_o),
  .rd_addr_o     (rd_addr_o),
  .iff1_o        (iff1_o),
  .iff2_o        (iff2_o),
  .mode_o        (mode_o)
);

// File: tb/irq_response_unit_bench.sv
`timescale 1ns/1ps
module irq_response_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, nmi = 1'b0;
  logic        en_stb = 1'b0, dis_stb = 1'b0, ret_stb = 1'b0;
  logic        mode_ld = 1'b0;
  logic [1:0]  mode_val = 2'd0;
  logic [7:0]  page = 8'h00, dev = 8'h00;
  logic [7:0]  rd_data = 8'h00;
  logic        take, inject, push_req, rd_req, iff1, iff2;
  logic [15:0] target, rd_addr;
  logic [7:0]  inject_op;
  logic [1:0]  mode;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_response_unit u_irq_response_unit (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .nmi_i(nmi),
    .en_stb_i(en_stb), .dis_stb_i(dis_stb), .nmi_ret_stb_i(ret_stb),
    .mode_ld_i(mode_ld), .mode_val_i(mode_val), .page_i(page),
    .dev_byte_i(dev), .rd_data_i(rd_data), .take_o(take), .target_o(target),
    .inject_o(inject), .inject_op_o(inject_op), .push_req_o(push_req),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .iff1_o(iff1), .iff2_o(iff2),
    .mode_o(mode)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h5C;
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= memf(rd_addr);

  function automatic logic [15:0] exp_tgt(input logic [1:0] m, input logic [7:0] p,
                                          input logic [7:0] d);
    if (m == 2'd1) return 16'h0038;
    if (m == 2'd0) return {10'b0, d[5:3], 3'b000};
    return {memf({p, d | 8'h01}), memf({p, d & 8'hFE})};
  endfunction

  typedef struct packed {
    logic [1:0] m;
    logic [7:0] p;
    logic [7:0] d;
    logic [3:0] lat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h00, 8'hFF, 4'd1},
    '{2'd1, 8'h3C, 8'h12, 4'd1},
    '{2'd0, 8'h00, 8'hFF, 4'd1},
    '{2'd0, 8'h11, 8'hC7, 4'd1},
    '{2'd0, 8'h22, 8'hD7, 4'd1},
    '{2'd2, 8'h80, 8'h13, 4'd4},
    '{2'd2, 8'hFF, 8'hFF, 4'd4},
    '{2'd2, 8'h00, 8'h00, 4'd4}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_ld = 1'b1; mode_val = m; cyc(); mode_ld = 1'b0;
  endtask

  task automatic strobe_en();  en_stb = 1'b1;  cyc(); en_stb = 1'b0;  endtask
  task automatic strobe_dis(); dis_stb = 1'b1; cyc(); dis_stb = 1'b0; endtask
  task automatic strobe_ret(); ret_stb = 1'b1; cyc(); ret_stb = 1'b0; endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    int rdn;
    logic [15:0] tbl;
    repeat (4) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    chk("R1", "iff1", iff1, 0);
    chk("R1", "iff2", iff2, 0);
    chk("R1", "mode", mode, 0);
    chk("R1", "take", take, 0);
    chk("R1", "push", push_req, 0);
    chk("R1", "rd_req", rd_req, 0);

    // Vector table walk: R5 R6 R7 R4
    for (int i = 0; i < NV; i++) begin
      set_mode(VECS[i].m);
      page = VECS[i].p; dev = VECS[i].d;
      strobe_en();
      irq_req = 1'b1;
      cyc();
      irq_req = 1'b0;
      chk("R4", "push after accept", push_req, 1);
      chk("R4", "iff1 cleared", iff1, 0);
      chk("R4", "iff2 cleared", iff2, 0);
      tbl = {VECS[i].p, VECS[i].d & 8'hFE};
      lat = 1; rdn = 0;
      while (!take && lat < 8) begin
        if (rd_req) begin
          chk("R7", "table read address", rd_addr, tbl + 16'(rdn));
          rdn++;
        end
        cyc(); lat++;
      end
      chk(VECS[i].m == 2'd2 ? "R7" : (VECS[i].m == 2'd1 ? "R5" : "R6"),
          "take latency", lat, VECS[i].lat);
      chk("R5", "target", target, exp_tgt(VECS[i].m, VECS[i].p, VECS[i].d));
      chk("R6", "inject flag", inject, VECS[i].m == 2'd0);
      if (VECS[i].m == 2'd0) chk("R6", "inject op", inject_op, VECS[i].d);
      if (VECS[i].m == 2'd2) chk("R7", "two reads", rdn, 2);
      cyc();
      chk("R12", "take single pulse", take, 0);
    end

    // R2 strobes
    strobe_en();
    chk("R2", "en sets iff1", iff1, 1);
    chk("R2", "en sets iff2", iff2, 1);
    en_stb = 1'b1; dis_stb = 1'b1; cyc(); en_stb = 1'b0; dis_stb = 1'b0;
    chk("R2", "dis wins iff1", iff1, 0);
    chk("R2", "dis wins iff2", iff2, 0);

    // R3 reserved code ignored
    set_mode(2'd2);
    chk("R3", "mode 2 loaded", mode, 2);
    set_mode(2'd3);
    chk("R3", "code 3 ignored", mode, 2);

    // R4 masked request ignored
    irq_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R4", "no push when masked", push_req, 0);
      chk("R4", "no take when masked", take, 0);
    end
    irq_req = 1'b0;

    // R9 R8 R11: NMI and maskable in the same cycle
    set_mode(2'd1);
    strobe_en();
    nmi = 1'b1; irq_req = 1'b1;
    cyc();
    chk("R9", "nmi wins take", take, 1);
    chk("R9", "nmi target", target, 16'h0066);
    chk("R8", "push on nmi", push_req, 1);
    chk("R8", "iff1 cleared", iff1, 0);
    chk("R8", "iff2 saved", iff2, 1);
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R8", "held level no retrigger", take, 0);
    end
    nmi = 1'b0;
    strobe_ret();
    chk("R11", "iff1 restored", iff1, 1);
    cyc();
    chk("R9", "maskable after restore", take, 1);
    chk("R9", "maskable target", target, 16'h0038);
    irq_req = 1'b0;
    cyc();

    // R8 NMI while disabled
    strobe_dis();
    nmi = 1'b1;
    cyc();
    chk("R8", "nmi while disabled", take, 1);
    chk("R8", "nmi target disabled", target, 16'h0066);
    chk("R8", "iff2 copies zero", iff2, 0);
    nmi = 1'b0;
    strobe_ret();
    chk("R11", "iff1 restored to zero", iff1, 0);

    // R10 NMI during table read
    set_mode(2'd2);
    page = 8'h5A; dev = 8'h21;
    strobe_en();
    irq_req = 1'b1;
    cyc();
    irq_req = 1'b0; nmi = 1'b1;
    cyc(); cyc(); cyc();
    chk("R10", "table take first", take, 1);
    chk("R10", "table target", target, exp_tgt(2'd2, 8'h5A, 8'h21));
    cyc();
    chk("R12", "gap between takes", take, 0);
    cyc();
    chk("R10", "held nmi taken", take, 1);
    chk("R10", "held nmi target", target, 16'h0066);
    nmi = 1'b0;
    cyc();
    chk("R12", "push single pulse", push_req, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule